// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a CPU interrupt once a programmed number of visible scanlines has gone by. Four register writes reach it already decoded, each as a one-cycle strobe with a shared data byte:

- a direct load of the counter;
- a load of the reload value;
- an acknowledge that also disarms the counter;
- an arm.

A video timing source supplies three more inputs: a once-per-line pulse, the current line number and a flag that says whether rendering is on.

The counter tests its value before decrementing it. When a qualifying line pulse finds the counter at zero, the counter takes the reload value and the interrupt request goes high. The request is a level. It stays high until the acknowledge write or reset. Line pulses count only inside the visible window, only while rendering is on and only while the counter is armed. A register write in the same cycle as a line pulse takes priority, and that pulse is dropped.

Top module: `scanline_irq_counter`

## Requirements
- R1: A counter-load write stores the data byte in the counter. With the counter armed and loaded with C, the interrupt output stays low through qualifying pulses 1 to C and is high in the cycle after qualifying pulse C+1.
- R2: A firing pulse loads the counter from the reload register (written by the reload-value write). With reload value L, the next firing comes on the (L+1)-th qualifying pulse after it.
- R3: The acknowledge write drives the interrupt output low in the next cycle and disarms the counter. Later pulses leave the counter value unchanged until an arm write.
- R4: The arm write enables counting and changes neither the interrupt output nor the counter value.
- R5: Only line numbers 0 to 239 inclusive qualify. Pulses on any other line number do not change the counter.
- R6: A pulse while the rendering flag is low does not change the counter.
- R7: Once high, the interrupt output stays high through later pulses, later firings and non-acknowledge writes until an acknowledge write.
- R8: When any register write coincides with a line pulse, the write takes effect and the pulse is ignored.
- R9: While reset (active low) is asserted, the interrupt output is low. After reset the counter is disarmed, and both the counter and the reload value are zero.
- R10: An acknowledge write and an arm write in the same cycle leave the counter disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_cnt | input | 1 | Strobe: load the counter with wr_data |
| wr_latch | input | 1 | Strobe: load the reload value with wr_data |
| wr_ack | input | 1 | Strobe: disarm and clear the interrupt |
| wr_arm | input | 1 | Strobe: arm the counter |
| wr_data | input | 8 | Data byte for the load strobes |
| line_tick | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Current scanline number |
| render_on | input | 1 | Rendering-enabled flag |
| irq_o | output | 1 | Interrupt request level |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a register write and a line pulse. The bench drives a reload-value write or a counter write in the same cycle as a pulse on a visible line with rendering on. It then judges from how many further pulses it takes to fire that the pulse was dropped and the written value was kept. The second pair is the acknowledge and arm strobes together. After that cycle, a pulse that would fire at zero must leave the interrupt output low.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

   // Decoded register-write strobes, one bit per operation
   typedef struct packed {
      logic load_cnt;
      logic load_rel;
      logic ack;
      logic arm;
   } wr_req_t;

   function automatic logic any_write(input wr_req_t w);
      return w.load_cnt | w.load_rel | w.ack | w.arm;
   endfunction

endpackage

// File: rtl/scanirq_gate.sv
// Holds the arm state and decides whether a line pulse is a qualifying one
module scanirq_gate
   import scanirq_pkg::*;
#(
   parameter int LINE_W    = 9,
   parameter int VIS_FIRST = 0,
   parameter int VIS_LAST  = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_req_t           wr_i,
   input  logic              tick_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              render_i,
   output logic              qual_o
);

   localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(VIS_FIRST);
   localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(VIS_LAST);

   logic armed_q;
   logic in_win;

   // R3, R4, R10: acknowledge wins over arm
   always_ff @(posedge clk) begin
      if (!rst_n)         armed_q <= 1'b0;
      else if (wr_i.ack)  armed_q <= 1'b0;
      else if (wr_i.arm)  armed_q <= 1'b1;
   end

   // R5: window compare; a zero lower bound needs no compare
   generate
      if (VIS_FIRST == 0) begin : g_win_top_only
         assign in_win = (line_i <= LAST_L);
      end else begin : g_win_both
         assign in_win = (line_i >= FIRST_L) && (line_i <= LAST_L);
      end
   endgenerate

   // R6, R8: rendering gate and write priority
   assign qual_o = tick_i & in_win & render_i & armed_q & ~any_write(wr_i);

   a_r10_ack_over_arm : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i.ack && wr_i.arm) |=> !qual_o);

   a_r3_disarmed_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i.ack) |=> !qual_o);

endmodule

// File: rtl/scanirq_counter.sv
// Post-decrement down-counter with reload register
module scanirq_counter
   import scanirq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_req_t          wr_i,
   input  logic [CNT_W-1:0] data_i,
   input  logic             qual_i,
   output logic             fire_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rel_q;
   logic             at_zero;

   assign at_zero = (cnt_q == ZERO);
   assign fire_o  = qual_i & at_zero;

   // R1, R2: a direct load wins; else the value is tested, then reloaded or decremented
   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= ZERO;
      else if (wr_i.load_cnt) cnt_q <= data_i;
      else if (qual_i) begin
         if (at_zero)        cnt_q <= rel_q;
         else                cnt_q <= cnt_q - ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             rel_q <= ZERO;
      else if (wr_i.load_rel) rel_q <= data_i;
   end

   a_r1_direct_load : assert property (@(posedge clk) disable iff (!rst_n)
      wr_i.load_cnt |=> (cnt_q == $past(data_i)));

   a_r2_reload_on_fire : assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !wr_i.load_cnt) |=> (cnt_q == $past(rel_q)));

   a_r6_hold_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (!qual_i && !wr_i.load_cnt) |=> $stable(cnt_q));

endmodule

// File: rtl/scanirq_flag.sv
// Interrupt request level: set by a firing, cleared only by acknowledge
module scanirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic ack_i,
   output logic irq_o
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      irq_q <= 1'b0;
      else if (ack_i)  irq_q <= 1'b0;
      else if (fire_i) irq_q <= 1'b1;
   end

   assign irq_o = irq_q;

   a_r3_ack_clears : assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !irq_o);

   a_r7_level_held : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> irq_o);

   a_r1_rise_needs_fire : assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && !fire_i) |=> !irq_o);

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
   import scanirq_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int LINE_W    = 9,
   parameter int VIS_FIRST = 0,
   parameter int VIS_LAST  = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cnt,
   input  logic              wr_latch,
   input  logic              wr_ack,
   input  logic              wr_arm,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              line_tick,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              irq_o
);

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (VIS_FIRST < 0 || VIS_LAST < VIS_FIRST || VIS_LAST >= (1 << LINE_W)) begin : g_bad_win
         $error("visible window does not fit the line number width");
      end
   endgenerate

   wr_req_t wr;
   logic    qual;
   logic    fire;

   assign wr = '{load_cnt: wr_cnt, load_rel: wr_latch, ack: wr_ack, arm: wr_arm};

   scanirq_gate #(
      .LINE_W    (LINE_W),
      .VIS_FIRST (VIS_FIRST),
      .VIS_LAST  (VIS_LAST)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr),
      .tick_i   (line_tick),
      .line_i   (line_num),
      .render_i (render_on),
      .qual_o   (qual)
   );

   scanirq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr),
      .data_i (wr_data),
      .qual_i (qual),
      .fire_o (fire)
   );

   scanirq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire_i (fire),
      .ack_i  (wr_ack),
      .irq_o  (irq_o)
   );

   a_r8_write_blocks_tick : assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && (wr_cnt || wr_latch || wr_ack || wr_arm) && !irq_o) |=> !irq_o);

   a_r5_outside_window : assert property (@(posedge clk) disable iff (!rst_n)
      (line_num > LINE_W'(VIS_LAST)) |-> !fire);

endmodule

// File: tb/tb_scanline_irq_counter.sv
module tb_scanline_irq_counter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_cnt = 0, wr_latch = 0, wr_ack = 0, wr_arm = 0;
   logic [7:0] wr_data = '0;
   logic       line_tick = 0;
   logic [8:0] line_num = '0;
   logic       render_on = 0;
   logic       irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   scanline_irq_counter dut (
      .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_latch(wr_latch),
      .wr_ack(wr_ack), .wr_arm(wr_arm), .wr_data(wr_data),
      .line_tick(line_tick), .line_num(line_num), .render_on(render_on),
      .irq_o(irq_o));

   task automatic chk(input string rq, input logic exp);
      n_cmp++;
      if (irq_o !== exp) begin
         n_bad++;
         $display("FAIL %s irq_o actual=%0b expected=%0b at %0t", rq, irq_o, exp, $time);
      end
   endtask

   // One active cycle of strobes/pulse, driven and released on falling edges
   task automatic drive(input bit c, input bit l, input bit a, input bit e,
                        input logic [7:0] d, input bit tk, input logic [8:0] ln, input bit rn);
      @(negedge clk);
      wr_cnt = c; wr_latch = l; wr_ack = a; wr_arm = e; wr_data = d;
      line_tick = tk; line_num = ln; render_on = rn;
      @(negedge clk);
      wr_cnt = 0; wr_latch = 0; wr_ack = 0; wr_arm = 0; line_tick = 0;
   endtask

   task automatic w_cnt(input logic [7:0] d);   drive(1,0,0,0,d,0,0,1); endtask
   task automatic w_lat(input logic [7:0] d);   drive(0,1,0,0,d,0,0,1); endtask
   task automatic w_ack();                      drive(0,0,1,0,0,0,0,1); endtask
   task automatic w_arm();                      drive(0,0,0,1,0,0,0,1); endtask
   task automatic tick(input logic [8:0] ln, input bit rn); drive(0,0,0,0,0,1,ln,rn); endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] lats [6] = '{8'd0, 8'd1, 8'd2, 8'd7, 8'd100, 8'd255};

      // R9: reset state and disarmed after reset
      repeat (3) @(negedge clk);
      chk("R9", 1'b0);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin tick(10, 1); chk("R9", 1'b0); end
      w_arm(); tick(10, 1); chk("R9", 1'b1);        // counter was zero
      w_ack(); chk("R3", 1'b0);
      w_arm(); tick(10, 1); chk("R9", 1'b1);        // reload value was zero

      // R1: every load value 0..255
      for (int c = 0; c < 256; c++) begin
         w_ack(); w_lat(8'hFF); w_cnt(8'(c)); w_arm();
         for (int k = 1; k <= c; k++) begin tick(9'(k % 240), 1); chk("R1", 1'b0); end
         tick(100, 1); chk("R1", 1'b1);
      end

      // R2: reload value sets the following period
      foreach (lats[i]) begin
         w_ack(); w_lat(lats[i]); w_cnt(0); w_arm();
         tick(50, 1); chk("R2", 1'b1);
         w_ack(); w_arm(); chk("R2", 1'b0);
         for (int k = 1; k <= int'(lats[i]); k++) begin tick(60, 1); chk("R2", 1'b0); end
         tick(60, 1); chk("R2", 1'b1);
      end

      // R3 and R4: disarmed pulses keep the value; arming does not change it
      w_ack(); w_cnt(2); w_arm(); w_ack(); chk("R3", 1'b0);
      for (int k = 0; k < 5; k++) begin tick(30, 1); chk("R3", 1'b0); end
      w_arm(); chk("R4", 1'b0);
      tick(30, 1); chk("R4", 1'b0);
      tick(30, 1); chk("R4", 1'b0);
      tick(30, 1); chk("R3", 1'b1);
      w_arm(); chk("R4", 1'b1);

      // R7: level held through writes and further firings
      w_lat(0); chk("R7", 1'b1);
      w_cnt(0); chk("R7", 1'b1);
      for (int k = 0; k < 4; k++) begin tick(70, 1); chk("R7", 1'b1); end

      // R5: window bounds
      w_ack(); w_cnt(1); w_arm();
      tick(240, 1); chk("R5", 1'b0);
      tick(261, 1); chk("R5", 1'b0);
      tick(511, 1); chk("R5", 1'b0);
      tick(239, 1); chk("R5", 1'b0);
      tick(0, 1);   chk("R5", 1'b1);
      w_ack(); w_cnt(0); w_arm();
      tick(240, 1); chk("R5", 1'b0);
      tick(239, 1); chk("R5", 1'b1);

      // R6: rendering off
      w_ack(); w_cnt(0); w_arm();
      for (int k = 0; k < 3; k++) begin tick(5, 0); chk("R6", 1'b0); end
      tick(5, 1); chk("R6", 1'b1);

      // R8: write and pulse in the same cycle
      w_ack(); w_lat(9); w_cnt(1); w_arm();
      drive(0,1,0,0,8'd3,1,9'd20,1); chk("R8", 1'b0);
      tick(20, 1); chk("R8", 1'b0);
      tick(20, 1); chk("R8", 1'b1);
      w_ack(); w_arm();                               // counter now 3
      drive(1,0,0,0,8'd0,1,9'd20,1); chk("R8", 1'b0); // counter 0, pulse dropped
      tick(20, 1); chk("R8", 1'b1);
      w_ack(); w_cnt(0); w_arm();
      drive(0,0,0,1,8'd0,1,9'd20,1); chk("R8", 1'b0); // arm with pulse: pulse dropped
      tick(20, 1); chk("R8", 1'b1);

      // R10: acknowledge and arm together
      w_ack(); w_cnt(0); w_arm();
      drive(0,0,1,1,8'd0,0,9'd0,1); chk("R10", 1'b0);
      tick(40, 1); chk("R10", 1'b0);

      // R9: reset in the middle of operation
      w_arm(); tick(40, 1); chk("R9", 1'b1);
      w_lat(5);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); chk("R9", 1'b0);
      rst_n = 1'b1;
      tick(40, 1); chk("R9", 1'b0);
      w_arm(); tick(40, 1); chk("R9", 1'b1);
      w_ack(); w_arm(); tick(40, 1); chk("R9", 1'b1);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule